// File: doc/BRIEF.md
# Ring-Fed Command Sequencer

The block carries out maintenance commands that software stages in a ring of 16-byte descriptors in system memory. Software fills a slot and then moves the tail pointer forward. The engine notices that the ring holds work whenever head and tail differ. It then:

- reads the descriptor at the head slot;
- decodes the opcode;
- hands the command to the translation-cache or context logic over a valid/ready strobe.

It moves head forward once the command has been accepted, and wraps to slot zero at the configured ring size. Software tracks progress through the head pointer.

Strobes that have been accepted are not yet finished: each one returns later as a one-cycle done pulse, and a small number may be in flight at the same time. A wait command is the barrier. It holds until every earlier strobe has reported done, then writes its 32-bit token to a memory address given in the descriptor, so software can poll that location. An unknown opcode freezes the engine with the error flag raised and head left on the bad slot. Software can then repair the slot or move head, and clear the flag to resume.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, head and tail read 0 and the error flag is low. No memory request, invalidation strobe or context strobe is active.
- R2: While head equals tail, the engine issues no memory request.
- R3: A descriptor is fetched as a memory read at `cfg_base + 16*head` and returned as 128 bits. The opcode is in bits [3:0]: 1 invalidates everything, 2 invalidates one source ID, 3 is a wait, and 4 is a context update. The source ID is in bits [31:16], the 32-bit data value in bits [63:32] and the wait target address in bits [64+AW-1:64].
- R4: Opcodes 1 and 2 raise `inv_valid`, with `inv_all` set only for opcode 1 and `inv_sid` taken from the descriptor. The request is held stable until `inv_ready`, and head advances on that handshake.
- R5: Opcode 4 raises `ctx_valid` with the descriptor's source ID and data value. Head advances on the handshake.
- R6: Commands take effect one at a time and in ring order. At most one of memory request, invalidation strobe and context strobe is active in any cycle.
- R7: A wait command writes its data value to its target address only once every previously accepted strobe has returned its done pulse. Head advances when that write is acknowledged.
- R8: No more than MAX_OUT accepted strobes are ever awaiting done. Further strobes are held back until a done pulse arrives.
- R9: Head steps to 0 instead of reaching `cfg_size`, so head stays below the ring size.
- R10: Any other opcode raises `err_flag`, stops all fetching and keeps head on the faulty slot. Pulsing `err_clr` refetches that slot.
- R11: A tail or head write whose value is not below `cfg_size` is ignored. A head write is also ignored unless the engine is idle or halted on an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | Byte address of ring slot 0 |
| cfg_size | input | PW+1 | Ring size in slots |
| tail_wr_en | input | 1 | Tail register write strobe |
| tail_wr_data | input | PW | New tail value |
| head_wr_en | input | 1 | Head register write strobe |
| head_wr_data | input | PW | New head value |
| head_q | output | PW | Current head slot |
| tail_q | output | PW | Current tail slot |
| err_flag | output | 1 | Halted on an illegal opcode |
| err_clr | input | 1 | Clears the error flag and resumes |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = descriptor read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Wait token to write |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 128 | Descriptor read data, valid with the acknowledge |
| inv_valid | output | 1 | Invalidation request |
| inv_ready | input | 1 | Invalidation request accepted |
| inv_all | output | 1 | 1 = flush all, 0 = flush one source ID |
| inv_sid | output | SIDW | Source ID to flush |
| inv_done | input | 1 | One accepted invalidation has finished |
| ctx_valid | output | 1 | Context update request |
| ctx_ready | input | 1 | Context update accepted |
| ctx_sid | output | SIDW | Source ID of the context |
| ctx_data | output | 32 | Context value |
| ctx_done | input | 1 | One accepted context update has finished |

## Verification
The main path is driven with a ring of mixed commands that is longer than the ring size, covering both invalidation flavours, context updates and waits. This shows that the decode is right, that fields come from the correct bits and that head wraps. Withholding done pulses behind a wait separates a real barrier from one that only orders issue. A burst of strobes with no completions exposes the in-flight cap. An illegal opcode, a stalled ready, and register writes that are out of range or arrive while busy check that the engine freezes and that writes are filtered as required.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the ring-fed command sequencer.
// Assumes 16-byte descriptors with fixed field positions.
package cmdq_pkg;

    localparam int DESC_W      = 128;
    localparam int SLOT_LG     = 4;     // log2 of descriptor bytes
    localparam int OP_LSB      = 0;
    localparam int OP_W        = 4;
    localparam int SID_LSB     = 16;
    localparam int DATA_LSB    = 32;
    localparam int DATA_W      = 32;
    localparam int ADDR_LSB    = 64;

    localparam logic [OP_W-1:0] OP_FLUSH_ALL = 4'd1;
    localparam logic [OP_W-1:0] OP_FLUSH_SID = 4'd2;
    localparam logic [OP_W-1:0] OP_BARRIER   = 4'd3;
    localparam logic [OP_W-1:0] OP_CTX_UPD   = 4'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_DRAIN,
        ST_WRITE,
        ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        K_FLUSH_ALL,
        K_FLUSH_SID,
        K_BARRIER,
        K_CTX_UPD,
        K_BAD
    } cmd_kind_e;

    // Map a raw opcode onto a command kind; unknown values are K_BAD.
    function automatic cmd_kind_e op_to_kind(input logic [OP_W-1:0] op);
        cmd_kind_e k;
        case (op)
            OP_FLUSH_ALL: k = K_FLUSH_ALL;
            OP_FLUSH_SID: k = K_FLUSH_SID;
            OP_BARRIER:   k = K_BARRIER;
            OP_CTX_UPD:   k = K_CTX_UPD;
            default:      k = K_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cmdq_ring_ptr.sv
`timescale 1ns/1ps
// Head and tail pointer registers of the descriptor ring.
// Head steps with wrap at cfg_size; software writes are range-filtered.
// Assumes cfg_size is stable and at least 1 while the engine runs.
module cmdq_ring_ptr #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW:0]   cfg_size,
    input  logic          tail_wr_en,
    input  logic [PW-1:0] tail_wr_data,
    input  logic          head_wr_en,
    input  logic [PW-1:0] head_wr_data,
    input  logic          head_wr_allow,
    input  logic          step,
    output logic [PW-1:0] head_q,
    output logic [PW-1:0] tail_q,
    output logic          empty
);

    logic [PW:0]   head_inc;
    logic [PW-1:0] head_wrapped;
    logic          tail_ok;
    logic          head_ok;

    // Next head slot with wrap to zero at the ring size.
    always_comb begin
        head_inc     = {1'b0, head_q} + {{PW{1'b0}}, 1'b1};
        head_wrapped = (head_inc >= cfg_size) ? '0 : head_inc[PW-1:0];
    end

    // Software writes are accepted only when in range (and head only when allowed).
    always_comb begin
        tail_ok = tail_wr_en && ({1'b0, tail_wr_data} < cfg_size);
        head_ok = head_wr_en && head_wr_allow && ({1'b0, head_wr_data} < cfg_size);
    end

    // Head register: hardware step has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (step) begin
            head_q <= head_wrapped;
        end else if (head_ok) begin
            head_q <= head_wr_data;
        end
    end

    // Tail register: owned by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
        end else if (tail_ok) begin
            tail_q <= tail_wr_data;
        end
    end

    assign empty = (head_q == tail_q);

endmodule

// File: rtl/cmdq_pending.sv
`timescale 1ns/1ps
// Counts accepted strobes that have not yet reported done.
// Two done sources may pulse in the same cycle; spurious dones saturate at zero.
module cmdq_pending #(
    parameter int MAX_OUT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic done_a,
    input  logic done_b,
    output logic full,
    output logic zero
);

    localparam int CW  = $clog2(MAX_OUT + 1);
    localparam int CW1 = CW + 1;
    localparam logic [CW-1:0] CAP = CW'(MAX_OUT);

    logic [CW-1:0] cnt;
    logic [CW:0]   up;
    logic [CW:0]   dn;
    logic [CW:0]   nxt;

    // Net change of the in-flight count this cycle.
    always_comb begin
        up  = {1'b0, cnt} + CW1'(issue);
        dn  = CW1'(done_a) + CW1'(done_b);
        nxt = (up > dn) ? (up - dn) : '0;
    end

    // In-flight counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= nxt[CW-1:0];
        end
    end

    assign full = (cnt >= CAP);
    assign zero = (cnt == '0);

endmodule

// File: rtl/cmdq_ctrl.sv
`timescale 1ns/1ps
// Sequencer state machine: fetch, decode, issue, barrier drain, token write, halt.
// Assumes one memory transaction at a time, acknowledged by mem_ack.
module cmdq_ctrl
    import cmdq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PW   = 8,
    parameter int SIDW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                empty,
    input  logic [PW-1:0]       head_q,
    input  logic [AW-1:0]       cfg_base,
    input  logic                err_clr,
    input  logic                pend_full,
    input  logic                pend_zero,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DESC_W-1:0]   mem_rdata,
    output logic                inv_valid,
    input  logic                inv_ready,
    output logic                inv_all,
    output logic [SIDW-1:0]     inv_sid,
    output logic                ctx_valid,
    input  logic                ctx_ready,
    output logic [SIDW-1:0]     ctx_sid,
    output logic [DATA_W-1:0]   ctx_data,
    output logic                issue,
    output logic                step,
    output logic                ptr_wr_allow,
    output logic                err_flag
);

    seq_state_e          state_q, state_d;
    logic [DESC_W-1:0]   desc_q;
    cmd_kind_e           kind;
    logic                is_flush;
    logic [AW-1:0]       fetch_addr;

    // Decode the latched descriptor.
    always_comb begin
        kind     = op_to_kind(desc_q[OP_LSB +: OP_W]);
        is_flush = (kind == K_FLUSH_ALL) || (kind == K_FLUSH_SID);
    end

    // Byte address of the head slot.
    assign fetch_addr = cfg_base + AW'({head_q, {SLOT_LG{1'b0}}});

    // Strobe outputs: presented only in EXEC and only with room in flight.
    always_comb begin
        inv_valid = (state_q == ST_EXEC) && is_flush && !pend_full;
        inv_all   = (kind == K_FLUSH_ALL);
        inv_sid   = desc_q[SID_LSB +: SIDW];
        ctx_valid = (state_q == ST_EXEC) && (kind == K_CTX_UPD) && !pend_full;
        ctx_sid   = desc_q[SID_LSB +: SIDW];
        ctx_data  = desc_q[DATA_LSB +: DATA_W];
        issue     = (inv_valid && inv_ready) || (ctx_valid && ctx_ready);
    end

    // Memory port: descriptor reads in FETCH, token write in WRITE.
    always_comb begin
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = (state_q == ST_WRITE) ? desc_q[ADDR_LSB +: AW] : fetch_addr;
        mem_wdata = desc_q[DATA_LSB +: DATA_W];
    end

    // Pointer control and status.
    always_comb begin
        step         = issue || ((state_q == ST_WRITE) && mem_ack);
        ptr_wr_allow = (state_q == ST_IDLE) || (state_q == ST_HALT);
        err_flag     = (state_q == ST_HALT);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (!empty) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack) state_d = ST_EXEC;
            ST_EXEC: begin
                case (kind)
                    K_FLUSH_ALL, K_FLUSH_SID, K_CTX_UPD: if (issue) state_d = ST_IDLE;
                    K_BARRIER: state_d = ST_DRAIN;
                    default:   state_d = ST_HALT;
                endcase
            end
            ST_DRAIN: if (pend_zero) state_d = ST_WRITE;
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            ST_HALT:  if (err_clr) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Descriptor holding register, loaded on the fetch acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
        end else if ((state_q == ST_FETCH) && mem_ack) begin
            desc_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/cmdq_engine.sv
`timescale 1ns/1ps
// Top of the ring-fed command sequencer: pointers, in-flight tracking, control.
// Assumes configuration inputs change only while the ring is empty.
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int PW      = 8,
    parameter int SIDW    = 16,
    parameter int MAX_OUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_base,
    input  logic [PW:0]       cfg_size,
    input  logic              tail_wr_en,
    input  logic [PW-1:0]     tail_wr_data,
    input  logic              head_wr_en,
    input  logic [PW-1:0]     head_wr_data,
    output logic [PW-1:0]     head_q,
    output logic [PW-1:0]     tail_q,
    output logic              err_flag,
    input  logic              err_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [127:0]      mem_rdata,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic              inv_all,
    output logic [SIDW-1:0]   inv_sid,
    input  logic              inv_done,
    output logic              ctx_valid,
    input  logic              ctx_ready,
    output logic [SIDW-1:0]   ctx_sid,
    output logic [31:0]       ctx_data,
    input  logic              ctx_done
);

    logic empty;
    logic step;
    logic issue;
    logic ptr_wr_allow;
    logic pend_full;
    logic pend_zero;

    cmdq_ring_ptr #(.PW(PW)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_size     (cfg_size),
        .tail_wr_en   (tail_wr_en),
        .tail_wr_data (tail_wr_data),
        .head_wr_en   (head_wr_en),
        .head_wr_data (head_wr_data),
        .head_wr_allow(ptr_wr_allow),
        .step         (step),
        .head_q       (head_q),
        .tail_q       (tail_q),
        .empty        (empty)
    );

    cmdq_pending #(.MAX_OUT(MAX_OUT)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (issue),
        .done_a (inv_done),
        .done_b (ctx_done),
        .full   (pend_full),
        .zero   (pend_zero)
    );

    cmdq_ctrl #(.AW(AW), .PW(PW), .SIDW(SIDW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .empty        (empty),
        .head_q       (head_q),
        .cfg_base     (cfg_base),
        .err_clr      (err_clr),
        .pend_full    (pend_full),
        .pend_zero    (pend_zero),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .inv_valid    (inv_valid),
        .inv_ready    (inv_ready),
        .inv_all      (inv_all),
        .inv_sid      (inv_sid),
        .ctx_valid    (ctx_valid),
        .ctx_ready    (ctx_ready),
        .ctx_sid      (ctx_sid),
        .ctx_data     (ctx_data),
        .issue        (issue),
        .step         (step),
        .ptr_wr_allow (ptr_wr_allow),
        .err_flag     (err_flag)
    );

endmodule

// File: rtl/cmdq_engine_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for cmdq_engine, attached by bind.
// Keeps its own count of strobes awaiting done.
module cmdq_engine_chk #(
    parameter int AW      = 32,
    parameter int PW      = 8,
    parameter int SIDW    = 16,
    parameter int MAX_OUT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   cfg_base,
    input logic [PW:0]     cfg_size,
    input logic            head_wr_en,
    input logic [PW-1:0]   head_q,
    input logic [PW-1:0]   tail_q,
    input logic            err_flag,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic            inv_valid,
    input logic            inv_ready,
    input logic            inv_all,
    input logic [SIDW-1:0] inv_sid,
    input logic            inv_done,
    input logic            ctx_valid,
    input logic            ctx_ready,
    input logic [SIDW-1:0] ctx_sid,
    input logic [31:0]     ctx_data,
    input logic            ctx_done
);

    int unsigned flight;

    // Independent in-flight count from handshakes and done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flight <= 0;
        end else begin
            flight <= flight + int'(inv_valid && inv_ready) + int'(ctx_valid && ctx_ready)
                      - int'(inv_done) - int'(ctx_done);
        end
    end

    a_r2_no_fetch_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(head_q != tail_q));

    a_r3_fetch_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr == cfg_base + AW'({head_q, 4'h0})));

    a_r4_inv_held: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_sid) && $stable(inv_all)));

    a_r5_ctx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_valid && !ctx_ready) |=> (ctx_valid && $stable(ctx_sid) && $stable(ctx_data)));

    a_r6_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_valid, ctx_valid, mem_req}));

    a_r7_barrier_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (flight == 0));

    a_r8_flight_cap: assert property (@(posedge clk) disable iff (!rst_n)
        flight <= MAX_OUT);

    a_r9_head_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, head_q} < cfg_size));

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!mem_req && !inv_valid && !ctx_valid));

    a_r10_halt_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && $past(err_flag) && !$past(head_wr_en)) |-> $stable(head_q));

endmodule

bind cmdq_engine cmdq_engine_chk #(
    .AW(AW), .PW(PW), .SIDW(SIDW), .MAX_OUT(MAX_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .head_wr_en(head_wr_en), .head_q(head_q), .tail_q(tail_q), .err_flag(err_flag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_all(inv_all), .inv_sid(inv_sid),
    .inv_done(inv_done), .ctx_valid(ctx_valid), .ctx_ready(ctx_ready), .ctx_sid(ctx_sid),
    .ctx_data(ctx_data), .ctx_done(ctx_done)
);

// File: tb/cmdq_engine_bench.sv
`timescale 1ns/1ps
module cmdq_engine_bench;

    localparam int AW = 32, PW = 8, SIDW = 16, MAXO = 4;
    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam int          RSIZE = 8;
    localparam logic [31:0] WADDR = 32'h0000_2000;
    localparam int NV = 10;
    // {opcode[51:48], sid[47:32], data[31:0]}
    localparam logic [51:0] TBL [NV] = '{
        {4'd1, 16'h0000, 32'h0000_0000},
        {4'd2, 16'h00A5, 32'h0000_0000},
        {4'd4, 16'h0123, 32'h1357_9BDF},
        {4'd3, 16'h0000, 32'hDEAD_0001},
        {4'd2, 16'hFFFF, 32'h0000_0000},
        {4'd4, 16'h8001, 32'h0000_0042},
        {4'd1, 16'h7777, 32'h0000_0000},
        {4'd3, 16'h0000, 32'h0BAD_F00D},
        {4'd2, 16'h1234, 32'h0000_0000},
        {4'd4, 16'h0002, 32'hFFFF_FFFF}
    };

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] cfg_base = BASE;
    logic [PW:0] cfg_size = 9'(RSIZE);
    logic tail_wr_en = 0, head_wr_en = 0, err_clr = 0;
    logic [PW-1:0] tail_wr_data = 0, head_wr_data = 0;
    logic [PW-1:0] head_q, tail_q;
    logic err_flag, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, ctx_data;
    logic [127:0] mem_rdata;
    logic inv_valid, inv_all, inv_done, ctx_valid, ctx_done;
    logic inv_ready = 1, ctx_ready = 1;
    logic [SIDW-1:0] inv_sid, ctx_sid;

    logic [127:0] ring [16];
    logic [31:0] roff;
    int ev_n = 0, wr_n = 0, rd_count = 0;
    int ev_kind [64];
    int ev_sid [64];
    logic [31:0] ev_data [64];
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    bit wr_ok [64];
    int pend_inv, pend_ctx, ni, nc;
    bit done_en = 1;
    int checks = 0, failures = 0, tsw = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cmdq_engine #(.AW(AW), .PW(PW), .SIDW(SIDW), .MAX_OUT(MAXO)) u_cmdq_engine (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .tail_wr_en(tail_wr_en), .tail_wr_data(tail_wr_data),
        .head_wr_en(head_wr_en), .head_wr_data(head_wr_data),
        .head_q(head_q), .tail_q(tail_q), .err_flag(err_flag), .err_clr(err_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_all(inv_all), .inv_sid(inv_sid),
        .inv_done(inv_done), .ctx_valid(ctx_valid), .ctx_ready(ctx_ready),
        .ctx_sid(ctx_sid), .ctx_data(ctx_data), .ctx_done(ctx_done)
    );

    assign roff = mem_addr - BASE;
    assign mem_rdata = ring[roff[7:4]];

    // Memory model: acknowledge every other cycle, log reads and token writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack && !mem_we) rd_count = rd_count + 1;
            if (mem_req && mem_ack && mem_we) begin
                wr_addr[wr_n & 63] = mem_addr;
                wr_data[wr_n & 63] = mem_wdata;
                wr_ok[wr_n & 63]   = (pend_inv == 0) && (pend_ctx == 0);
                wr_n = wr_n + 1;
            end
        end
    end

    // Strobe sinks: log accepted strobes and return done pulses when enabled.
    always @(posedge clk) begin
        if (!rst_n) begin
            pend_inv <= 0; pend_ctx <= 0; inv_done <= 1'b0; ctx_done <= 1'b0;
        end else begin
            if (inv_valid && inv_ready) begin
                ev_kind[ev_n & 63] = inv_all ? 1 : 2;
                ev_sid[ev_n & 63]  = int'(inv_sid);
                ev_data[ev_n & 63] = 32'h0;
                ev_n = ev_n + 1;
            end
            if (ctx_valid && ctx_ready) begin
                ev_kind[ev_n & 63] = 4;
                ev_sid[ev_n & 63]  = int'(ctx_sid);
                ev_data[ev_n & 63] = ctx_data;
                ev_n = ev_n + 1;
            end
            ni = pend_inv + int'(inv_valid && inv_ready) - int'(inv_done);
            nc = pend_ctx + int'(ctx_valid && ctx_ready) - int'(ctx_done);
            pend_inv <= ni;
            pend_ctx <= nc;
            inv_done <= done_en && (ni > 0) && !inv_done;
            ctx_done <= done_en && (nc > 0) && !ctx_done;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [3:0] op, input logic [15:0] sid,
                                        input logic [31:0] data, input logic [31:0] addr);
        return {32'h0, addr, data, sid, 12'h0, op};
    endfunction

    task automatic push(input logic [127:0] d);
        ring[tsw] = d;
        tsw = (tsw + 1) % RSIZE;
        @(negedge clk);
        tail_wr_en = 1; tail_wr_data = PW'(tsw);
        @(negedge clk);
        tail_wr_en = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (head_q == tail_q && !mem_req && !inv_valid && !ctx_valid) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int e0, w0, r0, h0, slot;
        for (int i = 0; i < 16; i++) ring[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 head", head_q, 0);
        chk("R1 tail", tail_q, 0);
        chk("R1 err", err_flag, 0);
        chk("R1 idle outputs", {mem_req, inv_valid, ctx_valid}, 0);
        // R2 empty ring fetches nothing
        repeat (10) @(negedge clk);
        chk("R2 no read while empty", rd_count, 0);
        // R11 out-of-range tail write ignored
        tail_wr_en = 1; tail_wr_data = PW'(RSIZE); @(negedge clk); tail_wr_en = 0;
        repeat (4) @(negedge clk);
        chk("R11 tail out of range", tail_q, 0);

        // Table walk: R3 R4 R5 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic [3:0] op; logic [15:0] sid; logic [31:0] dat; int hexp;
            op = TBL[i][51:48]; sid = TBL[i][47:32]; dat = TBL[i][31:0];
            e0 = ev_n; w0 = wr_n; hexp = (tsw + 1) % RSIZE;
            push(mk(op, sid, dat, WADDR + 32'(i * 4)));
            drain();
            chk("R9 head wrap", head_q, hexp);
            if (op == 4'd3) begin
                chk("R7 token write count", wr_n, w0 + 1);
                chk("R7 token addr", wr_addr[w0 & 63], WADDR + 32'(i * 4));
                chk("R7 token data", wr_data[w0 & 63], dat);
            end else begin
                chk("R3 one strobe", ev_n, e0 + 1);
                chk("R3 kind", ev_kind[e0 & 63], (op == 4'd1) ? 1 : (op == 4'd2) ? 2 : 4);
                if (op == 4'd2) chk("R4 sid", ev_sid[e0 & 63], sid);
                if (op == 4'd4) begin
                    chk("R5 sid", ev_sid[e0 & 63], sid);
                    chk("R5 data", ev_data[e0 & 63], dat);
                end
            end
        end
        repeat (20) @(negedge clk);

        // R7 barrier waits for done pulses
        done_en = 0; w0 = wr_n; h0 = tsw;
        push(mk(4'd1, 16'h0, 32'h0, 32'h0));
        push(mk(4'd4, 16'h0055, 32'h0000_0066, 32'h0));
        push(mk(4'd3, 16'h0, 32'hCAFE_F00D, 32'h0000_3000));
        repeat (40) @(negedge clk);
        chk("R7 no write before done", wr_n, w0);
        chk("R7 head at barrier", head_q, (h0 + 2) % RSIZE);
        done_en = 1;
        drain();
        chk("R7 write after done", wr_n, w0 + 1);
        chk("R7 drained at write", wr_ok[w0 & 63], 1);
        chk("R7 token data", wr_data[w0 & 63], 32'hCAFE_F00D);

        // R8 in-flight cap
        repeat (20) @(negedge clk);
        done_en = 0; e0 = ev_n; h0 = tsw;
        for (int k = 0; k < 6; k++) push(mk(4'd2, 16'(16'h100 + k), 32'h0, 32'h0));
        repeat (60) @(negedge clk);
        chk("R8 capped strobes", ev_n, e0 + MAXO);
        chk("R8 head stalled", head_q, (h0 + MAXO) % RSIZE);
        done_en = 1;
        drain();
        chk("R8 all issued", ev_n, e0 + 6);
        for (int k = 0; k < 6; k++) chk("R6 ring order", ev_sid[(e0 + k) & 63], 16'h100 + k);
        repeat (20) @(negedge clk);

        // R4 backpressure and R11 head write while busy
        inv_ready = 0; slot = tsw; e0 = ev_n;
        push(mk(4'd1, 16'h0, 32'h0, 32'h0));
        repeat (10) @(negedge clk);
        chk("R4 held valid", inv_valid, 1);
        head_wr_en = 1; head_wr_data = PW'((slot + 3) % RSIZE); @(negedge clk); head_wr_en = 0;
        repeat (3) @(negedge clk);
        chk("R11 head write busy ignored", head_q, slot);
        inv_ready = 1;
        drain();
        chk("R4 accepted after ready", ev_n, e0 + 1);

        // R10 illegal opcode halts and resumes
        slot = tsw; e0 = ev_n;
        push(mk(4'hF, 16'h0, 32'h0, 32'h0));
        repeat (20) @(negedge clk);
        chk("R10 error flag", err_flag, 1);
        chk("R10 head on bad slot", head_q, slot);
        r0 = rd_count;
        repeat (20) @(negedge clk);
        chk("R10 fetch stopped", rd_count, r0);
        chk("R10 no strobe", ev_n, e0);
        ring[slot] = mk(4'd1, 16'h0, 32'h0, 32'h0);
        err_clr = 1; @(negedge clk); err_clr = 0;
        drain();
        chk("R10 error cleared", err_flag, 0);
        chk("R10 refetched slot", ev_n, e0 + 1);
        chk("R10 head moved", head_q, tsw);

        // R11 head and tail write while idle
        head_wr_en = 1; head_wr_data = 8'd5; tail_wr_en = 1; tail_wr_data = 8'd5;
        @(negedge clk);
        head_wr_en = 0; tail_wr_en = 0;
        repeat (3) @(negedge clk);
        chk("R11 idle head write", head_q, 5);
        tsw = 5; e0 = ev_n;
        push(mk(4'd2, 16'h0BEE, 32'h0, 32'h0));
        drain();
        chk("R11 fetch from new head", ev_sid[e0 & 63], 16'h0BEE);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule